// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of a video output. A pixel counter runs across each line and a line counter runs down each field. Both restart when software writes the restart register or, in slave mode, when an external sync pulse arrives. Software programs the line length in pixel clocks and the frame length in half-lines through a word-addressed register bus. An odd half-line count gives interlaced operation, in which top and bottom fields alternate.

From the counter position the block derives several outputs. One data-enable window is selected per field. Several sync outputs each have a horizontal window and a vertical window per field, and the vertical output of each changes state only at a programmable pixel of the line. The start of each field sets a status bit. Status bits are masked onto a single interrupt line, and software clears them by writing ones.

Top module: `raster_timer`

## Requirements
- R1: The pixel output counts 0, 1, ... up to line length minus one, then returns to 0, and the line advances. A line length of 0 or 1 keeps the pixel at 0.
- R2: Line numbers start at 1. With frame length F (half-lines), an even F gives fields of F/2 lines that are all top fields (field output 0). An odd F gives alternating fields: a top field of (F+1)/2 lines, then a bottom field (field output 1) of (F-1)/2 lines.
- R3: Every window register holds its exclusive end in bits 31:16 and its inclusive start in bits 15:0. Sync set k's horizontal output is high while start <= pixel < end. A window whose start equals its end is never high.
- R4: Sync set k's vertical output takes the value (start <= line < end) of the vertical window for the current field. The top window is at address 17+4k and the bottom window at 18+4k. It updates only on the clock edge at which the pixel equals the field's edge position, one cycle later at the output. The edge register at 19+4k holds the top position in bits 15:0 and the bottom position in bits 31:16. The horizontal window of set k is at 16+4k.
- R5: Data enable is high when org.line <= line < end.line and org.pixel <= pixel < end.pixel. Each of org and end holds the line in bits 31:16 and the pixel in bits 15:0. The top field uses the registers at addresses 4 (org) and 5 (end); the bottom field uses 6 (org) and 7 (end).
- R6: The clock edge at which the counters sit at pixel 0, line 1 sets status bit 1 for a top field or status bit 0 for a bottom field. The status register reads at address 8.
- R7: Writing to address 9 clears each status bit whose data bit is 1. A field event in the same cycle wins over the clear.
- R8: Writing to address 12 sets mask bits and writing to address 11 clears them, in both cases where the data bit is 1. The mask reads at address 10. The interrupt output is high when any status bit is set together with its mask bit.
- R9: Writing address 3 with bit 0 set puts the counters at pixel 0, line 1, top field on that clock edge. Writing address 3 with bit 0 clear has no effect.
- R10: Bit 0 of address 0 selects the mode. In mode 0 the external sync input is ignored. In mode 1, external sync high at a clock edge restarts the counters as in R9.
- R11: After reset every register is zero, so all sync, enable and interrupt outputs are low.
- R12: The line length (address 1) and frame length (address 2) read back the value written in bits 15:0. The mode reads back in bit 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| ext_sync_i | input | 1 | external restart pulse for slave mode |
| we_i | input | 1 | register write strobe |
| addr_i | input | AW | register word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i |
| pix_o | output | 16 | current pixel number |
| line_o | output | 16 | current line number |
| field_o | output | 1 | 0 top field, 1 bottom field |
| de_o | output | 1 | active-video enable |
| hs_o | output | NSYNC | horizontal outputs of the sync sets |
| vs_o | output | NSYNC | vertical outputs of the sync sets |
| irq_o | output | 1 | masked field interrupt |

## Verification
The bench keeps the default four sync sets and an 8-bit address, and programs a raster of 8 pixels per line. This makes a whole frame only a few dozen cycles long, so every pixel and line position is compared against an arithmetic model across several frames. It first uses a progressive frame of 10 half-lines and then an interlaced frame of 7. Each sync set gets different windows and edge positions, one of them an empty window, so every field's windows, both edge pixels and the top/bottom line split are all reached.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned PW = 16;

  localparam int A_MODE      = 0;
  localparam int A_LLEN      = 1;
  localparam int A_FLEN      = 2;
  localparam int A_RST       = 3;
  localparam int A_ACT       = 4;  // 4 top org, 5 top end, 6 bot org, 7 bot end
  localparam int A_STAT      = 8;
  localparam int A_STAT_CLR  = 9;
  localparam int A_MASK      = 10;
  localparam int A_MASK_CLR  = 11;
  localparam int A_MASK_SET  = 12;
  localparam int A_SYNC_BASE = 16; // 4 words per sync set

  typedef enum logic {FLD_TOP = 1'b0, FLD_BOT = 1'b1} field_e;

  function automatic logic in_win(input logic [PW-1:0] pos, input logic [DW-1:0] w);
    return (pos >= w[PW-1:0]) && (pos < w[DW-1:PW]);
  endfunction
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned NSYNC = 4,
  parameter int unsigned AW    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic                      ev_top_i,
  input  logic                      ev_bot_i,
  output logic                      mode_o,
  output logic [PW-1:0]             llen_o,
  output logic [PW-1:0]             flen_o,
  output logic                      restart_o,
  output logic [3:0][DW-1:0]        act_o,
  output logic [NSYNC-1:0][DW-1:0]  hwin_o,
  output logic [NSYNC-1:0][DW-1:0]  vtop_o,
  output logic [NSYNC-1:0][DW-1:0]  vbot_o,
  output logic [NSYNC-1:0][DW-1:0]  vedge_o,
  output logic [1:0]                stat_o,
  output logic [1:0]                mask_o
);
  logic [1:0] stat_clr, mask_clr, mask_set;

  assign stat_clr  = (we_i && addr_i == AW'(A_STAT_CLR)) ? wdata_i[1:0] : 2'b00;
  assign mask_clr  = (we_i && addr_i == AW'(A_MASK_CLR)) ? wdata_i[1:0] : 2'b00;
  assign mask_set  = (we_i && addr_i == AW'(A_MASK_SET)) ? wdata_i[1:0] : 2'b00;
  assign restart_o = we_i && addr_i == AW'(A_RST) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= 1'b0;
      llen_o  <= '0;
      flen_o  <= '0;
      act_o   <= '0;
      hwin_o  <= '0;
      vtop_o  <= '0;
      vbot_o  <= '0;
      vedge_o <= '0;
      stat_o  <= '0;
      mask_o  <= '0;
    end else begin
      // a field event outranks a clear in the same cycle
      stat_o <= (stat_o & ~stat_clr) | {ev_top_i, ev_bot_i};
      mask_o <= (mask_o & ~mask_clr) | mask_set;
      if (we_i) begin
        if (addr_i == AW'(A_MODE)) mode_o <= wdata_i[0];
        if (addr_i == AW'(A_LLEN)) llen_o <= wdata_i[PW-1:0];
        if (addr_i == AW'(A_FLEN)) flen_o <= wdata_i[PW-1:0];
        for (int j = 0; j < 4; j++)
          if (addr_i == AW'(A_ACT + j)) act_o[j] <= wdata_i;
        for (int k = 0; k < int'(NSYNC); k++) begin
          if (addr_i == AW'(A_SYNC_BASE + 4*k))     hwin_o[k]  <= wdata_i;
          if (addr_i == AW'(A_SYNC_BASE + 4*k + 1)) vtop_o[k]  <= wdata_i;
          if (addr_i == AW'(A_SYNC_BASE + 4*k + 2)) vbot_o[k]  <= wdata_i;
          if (addr_i == AW'(A_SYNC_BASE + 4*k + 3)) vedge_o[k] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(A_MODE))      rdata_o = {{(DW-1){1'b0}}, mode_o};
    else if (addr_i == AW'(A_LLEN)) rdata_o = {{(DW-PW){1'b0}}, llen_o};
    else if (addr_i == AW'(A_FLEN)) rdata_o = {{(DW-PW){1'b0}}, flen_o};
    else if (addr_i == AW'(A_STAT)) rdata_o = {{(DW-2){1'b0}}, stat_o};
    else if (addr_i == AW'(A_MASK)) rdata_o = {{(DW-2){1'b0}}, mask_o};
  end
endmodule

// File: rtl/vtg_count.sv
module vtg_count
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] llen_i,
  input  logic [PW-1:0] flen_i,
  input  logic          restart_i,
  output logic [PW-1:0] pix_o,
  output logic [PW-1:0] line_o,
  output field_e        fld_o,
  output logic          ev_top_o,
  output logic          ev_bot_o
);
  logic [PW-1:0] field_lines;
  logic [PW:0]   pix_nx;
  logic          eol, eof;

  // odd half-line count: the top field takes the extra line
  assign field_lines = {1'b0, flen_i[PW-1:1]} + PW'(flen_i[0] && fld_o == FLD_TOP);
  assign pix_nx      = {1'b0, pix_o} + (PW+1)'(1);
  assign eol         = pix_nx >= {1'b0, llen_i};
  assign eof         = line_o >= field_lines;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o  <= '0;
      line_o <= PW'(1);
      fld_o  <= FLD_TOP;
    end else if (restart_i) begin
      pix_o  <= '0;
      line_o <= PW'(1);
      fld_o  <= FLD_TOP;
    end else if (eol) begin
      pix_o <= '0;
      if (eof) begin
        line_o <= PW'(1);
        fld_o  <= flen_i[0] ? field_e'(~fld_o) : FLD_TOP;
      end else begin
        line_o <= line_o + PW'(1);
      end
    end else begin
      pix_o <= pix_nx[PW-1:0];
    end
  end

  assign ev_top_o = pix_o == '0 && line_o == PW'(1) && fld_o == FLD_TOP;
  assign ev_bot_o = pix_o == '0 && line_o == PW'(1) && fld_o == FLD_BOT;
endmodule

// File: rtl/vtg_sync.sv
module vtg_sync
  import vtg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pix_i,
  input  logic [PW-1:0] line_i,
  input  field_e        fld_i,
  input  logic [DW-1:0] hwin_i,
  input  logic [DW-1:0] vtop_i,
  input  logic [DW-1:0] vbot_i,
  input  logic [DW-1:0] vedge_i,
  output logic          hs_o,
  output logic          vs_o
);
  logic [PW-1:0] edge_pos;
  logic          v_hit;

  assign hs_o     = in_win(pix_i, hwin_i);
  assign edge_pos = (fld_i == FLD_BOT) ? vedge_i[DW-1:PW] : vedge_i[PW-1:0];
  assign v_hit    = in_win(line_i, (fld_i == FLD_BOT) ? vbot_i : vtop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                vs_o <= 1'b0;
    else if (pix_i == edge_pos) vs_o <= v_hit;
  end
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import vtg_pkg::*;
#(
  parameter int unsigned NSYNC = 4,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sync_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic [15:0]      pix_o,
  output logic [15:0]      line_o,
  output logic             field_o,
  output logic             de_o,
  output logic [NSYNC-1:0] hs_o,
  output logic [NSYNC-1:0] vs_o,
  output logic             irq_o
);
  logic                     mode, reg_restart, restart, ev_top, ev_bot;
  logic [PW-1:0]            llen, flen;
  logic [3:0][DW-1:0]       act;
  logic [NSYNC-1:0][DW-1:0] hwin, vtop, vbot, vedge;
  logic [1:0]               irq_stat, irq_mask;
  field_e                   fld;
  logic [DW-1:0]            org, fin;

  vtg_regs #(.NSYNC(NSYNC), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ev_top_i(ev_top), .ev_bot_i(ev_bot),
    .mode_o(mode), .llen_o(llen), .flen_o(flen), .restart_o(reg_restart),
    .act_o(act), .hwin_o(hwin), .vtop_o(vtop), .vbot_o(vbot), .vedge_o(vedge),
    .stat_o(irq_stat), .mask_o(irq_mask)
  );

  assign restart = reg_restart || (mode && ext_sync_i);

  vtg_count u_count (
    .clk_i, .rst_ni, .llen_i(llen), .flen_i(flen), .restart_i(restart),
    .pix_o, .line_o, .fld_o(fld), .ev_top_o(ev_top), .ev_bot_o(ev_bot)
  );

  for (genvar k = 0; k < int'(NSYNC); k++) begin : g_sync
    vtg_sync u_sync (
      .clk_i, .rst_ni, .pix_i(pix_o), .line_i(line_o), .fld_i(fld),
      .hwin_i(hwin[k]), .vtop_i(vtop[k]), .vbot_i(vbot[k]), .vedge_i(vedge[k]),
      .hs_o(hs_o[k]), .vs_o(vs_o[k])
    );
  end

  assign field_o = (fld == FLD_BOT);
  assign org     = field_o ? act[2] : act[0];
  assign fin     = field_o ? act[3] : act[1];
  assign de_o    = in_win(line_o, {fin[DW-1:PW], org[DW-1:PW]}) &&
                   in_win(pix_o,  {fin[PW-1:0],  org[PW-1:0]});
  assign irq_o   = |(irq_stat & irq_mask);
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [31:0]   wdata_i,
  input logic [15:0]   pix_o,
  input logic [15:0]   line_o,
  input logic          field_o,
  input logic          irq_o,
  input logic [1:0]    stat,
  input logic [1:0]    mask
);
  assert_pix_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o != '0) |-> (pix_o == $past(pix_o) + 16'd1));

  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == '0 && line_o != 16'd1) |-> (line_o == $past(line_o) + 16'd1));

  assert_top_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_o == '0 && line_o == 16'd1 && !field_o) |=> stat[1]);

  assert_stat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == AW'(A_STAT_CLR) && wdata_i[0] &&
          !(pix_o == '0 && line_o == 16'd1 && field_o)) |-> !stat[0]);

  assert_mask_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == AW'(A_MASK_CLR) && wdata_i[1:0] == 2'b11) |-> !irq_o);

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i == AW'(A_RST) && wdata_i[0]) |->
      (pix_o == '0 && line_o == 16'd1 && !field_o));
endmodule

bind raster_timer vtg_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .pix_o(pix_o), .line_o(line_o), .field_o(field_o), .irq_o(irq_o),
  .stat(irq_stat), .mask(irq_mask)
);

// File: tb/sim_raster_timer.sv
`timescale 1ns/1ps
module sim_raster_timer;
  import vtg_pkg::*;

  localparam int NS = 4;
  localparam int LL = 8;

  logic          clk = 1'b0, rst_n = 1'b0, ext_sync = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [15:0]   pix, line;
  logic          field, de, irq;
  logic [NS-1:0] hs, vs;

  int total = 0, bad = 0, fl = 10;
  bit done = 0;

  int m_px, m_ln;
  bit m_bot;
  bit [NS-1:0] m_vs, m_vsk;
  bit [1:0] m_st;

  always #2.5 clk = ~clk;

  raster_timer #(.NSYNC(NS), .AW(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_sync_i(ext_sync), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pix_o(pix), .line_o(line), .field_o(field),
    .de_o(de), .hs_o(hs), .vs_o(vs), .irq_o(irq)
  );

  function automatic bit hit(int p, int s, int e);
    return p >= s && p < e;
  endfunction

  function automatic int hw_end(int k);
    return (k == 3) ? 3 : k + 3;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 8'(a); wdata = 32'(d);
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    addr = 8'(a);
    #1 chk(rdata == 32'(exp), tag, rdata, exp);
  endtask

  // one clock edge of the reference model
  task automatic model_step();
    int lines;
    for (int k = 0; k < NS; k++) begin
      if (m_px == (m_bot ? 7 - k : k)) begin
        m_vs[k]  = m_bot ? hit(m_ln, 2, 3) : hit(m_ln, 1, 2 + k);
        m_vsk[k] = 1'b1;
      end
    end
    if (m_px == 0 && m_ln == 1) m_st[m_bot ? 0 : 1] = 1'b1;
    lines = fl / 2 + ((fl % 2 == 1 && !m_bot) ? 1 : 0);
    if (m_px + 1 >= LL) begin
      m_px = 0;
      if (m_ln >= lines) begin
        m_ln  = 1;
        m_bot = (fl % 2 == 1) ? !m_bot : 1'b0;
      end else m_ln++;
    end else m_px++;
  endtask

  task automatic check_all();
    bit e_de;
    chk(pix == 16'(m_px), "R1 pixel", pix, m_px);
    chk(line == 16'(m_ln), "R2 line", line, m_ln);
    chk(field == m_bot, "R2 field", field, m_bot);
    for (int k = 0; k < NS; k++) begin
      chk(hs[k] == hit(m_px, k, hw_end(k)), "R3 hsync", hs[k], hit(m_px, k, hw_end(k)));
      if (m_vsk[k]) chk(vs[k] == m_vs[k], "R4 vsync", vs[k], m_vs[k]);
    end
    e_de = m_bot ? (hit(m_ln, 1, 3) && hit(m_px, 2, 6)) : (hit(m_ln, 2, 5) && hit(m_px, 1, 7));
    chk(de == e_de, "R5 enable", de, e_de);
    chk(irq == (|m_st), "R6 irq from field event", irq, |m_st);
  endtask

  task automatic sweep(input int f, input int n);
    fl = f;
    wr(A_FLEN, f);
    wr(A_RST, 1);
    @(negedge clk);
    we = 1'b1; addr = 8'(A_STAT_CLR); wdata = 32'd3;
    m_px = 0; m_ln = 1; m_bot = 1'b0; m_vsk = '0; m_vs = '0;
    model_step();
    m_st = 2'b10; // top event outranks the clear (R7)
    @(posedge clk);
    #1 we = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      model_step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(irq == 1'b0, "R11 irq", irq, 0);
    chk(hs == '0, "R11 hsync", hs, 0);
    chk(vs == '0, "R11 vsync", vs, 0);
    chk(de == 1'b0, "R11 enable", de, 0);
    rd_chk(A_MASK, 0, "R11 mask");
    rd_chk(A_LLEN, 0, "R11 line length");

    wr(A_LLEN, LL);
    wr(A_ACT + 0, (2 << 16) | 1);
    wr(A_ACT + 1, (5 << 16) | 7);
    wr(A_ACT + 2, (1 << 16) | 2);
    wr(A_ACT + 3, (3 << 16) | 6);
    for (int k = 0; k < NS; k++) begin
      wr(A_SYNC_BASE + 4*k,     (hw_end(k) << 16) | k);
      wr(A_SYNC_BASE + 4*k + 1, ((2 + k) << 16) | 1);
      wr(A_SYNC_BASE + 4*k + 2, (3 << 16) | 2);
      wr(A_SYNC_BASE + 4*k + 3, ((7 - k) << 16) | k);
    end
    wr(A_MASK_SET, 3);
    wr(A_FLEN, 10);
    @(negedge clk);
    rd_chk(A_LLEN, LL, "R12 line length");
    rd_chk(A_FLEN, 10, "R12 frame length");
    rd_chk(A_MASK, 3, "R8 mask set");
    rd_chk(13, 0, "R12 unmapped");

    sweep(10, 100);  // progressive: 5 lines per field
    sweep(7, 130);   // interlaced: 4-line top, 3-line bottom

    // R7: clear with simultaneous top event; bottom bit cleared
    wr(A_RST, 1);
    wr(A_STAT_CLR, 1);
    @(negedge clk);
    rd_chk(A_STAT, 2, "R7 clear with set winning");
    wr(A_STAT_CLR, 2);
    @(negedge clk);
    rd_chk(A_STAT, 0, "R7 clear");
    chk(irq == 1'b0, "R8 irq low with empty status", irq, 0);

    // R8: mask behaviour
    wr(A_MASK_CLR, 1);
    @(negedge clk);
    rd_chk(A_MASK, 2, "R8 mask clear");
    wr(A_RST, 1);
    @(negedge clk);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq with mask", irq, 1);
    wr(A_MASK_CLR, 2);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    rd_chk(A_STAT, 2, "R8 status kept when masked");
    wr(A_MASK_SET, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R8 other bit masked", irq, 0);
    wr(A_MASK_SET, 2);
    @(negedge clk);
    chk(irq == 1'b1, "R8 mask set again", irq, 1);

    // R9: restart write with bit 0 clear has no effect
    wr(A_RST, 1);
    wr(A_RST, 0);
    @(negedge clk);
    chk(pix == 16'd1, "R9 zero write ignored", pix, 1);
    wr(A_RST, 1);
    @(negedge clk);
    chk(pix == 16'd0 && line == 16'd1, "R9 restart", pix, 0);

    // R10: master ignores ext sync, slave restarts on it
    ext_sync = 1'b1;
    @(negedge clk);
    ext_sync = 1'b0;
    chk(pix == 16'd1, "R10 master ignores sync", pix, 1);
    wr(A_MODE, 1);
    @(negedge clk);
    rd_chk(A_MODE, 1, "R12 mode readback");
    ext_sync = 1'b1;
    @(negedge clk);
    ext_sync = 1'b0;
    chk(pix == 16'd0 && line == 16'd1, "R10 slave restart", pix, 0);
    @(negedge clk);
    chk(pix == 16'd1, "R10 slave runs on", pix, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule